// File: doc/BRIEF.md
# SPI Command Slave with Byte FIFOs

This block lets an external host reach a chip core over a four-wire serial link in clock mode 0. The serial clock, data and select pins are sampled into the system clock domain. Each time select goes low, the first full byte is a command. Its top three bits choose one of four operations and its low five bits carry either a register index or a burst length. A register access then moves one 16-bit word, high byte first. A FIFO access moves a burst of bytes: host writes go into a 32-entry receive queue, and host reads come out of a 32-entry transmit queue.

On the core side, the receive queue is drained and the transmit queue is filled through valid/ready byte streams. A beat moves on a rising clock edge where valid and ready are both high. The transmit push port drops ready while the queue holds 32 bytes. The receive pop port holds valid low while its queue is empty. Holding ready low on the pop port is the only back-pressure the core can apply. The serial side is never stalled: a host byte that arrives at a full receive queue is discarded and flagged.

A small register set holds the receive and transmit thresholds, five sticky receive-queue status flags, their enables, a write-one-to-clear port and the two fill counts. An interrupt request output is high while any enabled status flag is set. The serial clock must run at most one eighth of the system clock rate.

Top module: `spi_cmd_slave`

## Requirements
- R1: Framing follows mode 0. The slave takes MOSI on rising serial-clock edges, MSB first, in 8-bit frames, and moves MISO only after falling edges. MISO is 0 while select is high and throughout the command byte.
- R2: The command byte is decoded as follows. Bits [7:5] = 000 is a register read and 001 a register write, both only when bit 0 is 1, with the index in bits [4:1]. 011 is a FIFO read and 101 a FIFO write. Any other command, or a register command whose bit 0 is 0, is ignored for the rest of the select period, and MISO stays 0.
- R3: A register read returns 16 bits, high byte first. Index 0 gives the TX threshold in [11:6] and the RX threshold in [5:0], with reset value 0. Index 1 gives status, index 2 gives enables, and index 4 gives the RX count in [11:6] and the TX count in [5:0]. Index 3 and unused indices read 0.
- R4: A register write takes effect only once its second data byte is complete. Indices 0 and 2 are stored. Index 3 is a clear port. Indices 1 and 4 ignore writes.
- R5: A FIFO write pushes up to n received bytes into the RX queue, where n is bits [4:0] of the command and n=0 means 32. The core drains the bytes in arrival order on the rx_out stream.
- R6: A FIFO read sends up to n bytes from the TX queue, with the same length rule, in the order the core pushed them. tx_in_ready is low exactly while 32 bytes are held.
- R7: A FIFO-read byte slot that meets an empty TX queue sends 0x00 and leaves the TX count unchanged.
- R8: A FIFO-write byte that arrives while the RX queue holds 32 bytes is dropped and sets status bit 3 (overflow).
- R9: Status bits: [4] RX not empty, [3] overflow, [2] RX count above the RX threshold, [1] RX empty, [0] RX count below the RX threshold. Each bit is sticky. Writing 1 to the same bit of index 3 clears it, and the bit is set again at once if its condition still holds.
- R10: irq is high exactly when some status bit and its enable bit (index 2, same positions) are both 1.
- R11: Raising select aborts the command. A partial byte has no effect. Bytes beyond a burst's length, or after a register word, are ignored.
- R12: Each queue holds at most 32 bytes, and its count register never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low select from host |
| spi_miso | output | 1 | Serial data to host |
| irq | output | 1 | Interrupt request, active high |
| tx_in_valid | input | 1 | Core offers a byte for the TX queue |
| tx_in_ready | output | 1 | TX queue can accept a byte |
| tx_in_data | input | 8 | Byte pushed into the TX queue |
| rx_out_valid | output | 1 | RX queue holds a byte |
| rx_out_ready | input | 1 | Core takes the head byte |
| rx_out_data | output | 8 | Head byte of the RX queue |

## Verification
On every cycle, the assertions check the following. Queue counts stay within 32 and move by at most one per cycle. A FIFO-write byte that meets a full receive queue raises the overflow flag and never reaches the queue. An empty transmit queue stays empty unless the core pushes. MISO rests at 0 while select is high. Only the bench scenarios can show the rest, because those behaviours depend on whole byte sequences rather than on one cycle: command decoding and the high-byte-first register word, the length rule with zero meaning 32, burst truncation and aborts in mid-byte, zero fill from an empty transmit queue, and the clear-then-re-set behaviour of the status flags.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [2:0] {
    OP_RREG  = 3'b000,
    OP_WREG  = 3'b001,
    OP_RFIFO = 3'b011,
    OP_WFIFO = 3'b101
  } op_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_RD_HI,
    ST_RD_LO,
    ST_WR_HI,
    ST_WR_LO,
    ST_FRD,
    ST_FWR,
    ST_SKIP
  } st_e;

  localparam int REG_W   = 16;
  localparam int NSTAT   = 5;
  localparam int SB_UNT  = 0;
  localparam int SB_EMP  = 1;
  localparam int SB_OVT  = 2;
  localparam int SB_OVF  = 3;
  localparam int SB_NE   = 4;

  localparam logic [3:0] IX_THR = 4'd0;
  localparam logic [3:0] IX_STS = 4'd1;
  localparam logic [3:0] IX_ENA = 4'd2;
  localparam logic [3:0] IX_CLR = 4'd3;
  localparam logic [3:0] IX_CNT = 4'd4;
endpackage

// File: rtl/scs_shift.sv
module scs_shift #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       cs_n,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       sel,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [SYNC-1:0] sclk_sy, mosi_sy, cs_sy;
  logic            sclk_d;
  logic [2:0]      bit_cnt;
  logic [7:0]      rx_sr, tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      mosi_sy <= '0;
      cs_sy   <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC-2:0], sclk};
      mosi_sy <= {mosi_sy[SYNC-2:0], mosi};
      cs_sy   <= {cs_sy[SYNC-2:0], cs_n};
      sclk_d  <= sclk_sy[SYNC-1];
    end
  end

  logic sclk_s, mosi_s, cs_s, rise, fall;
  assign sclk_s = sclk_sy[SYNC-1];
  assign mosi_s = mosi_sy[SYNC-1];
  assign cs_s   = cs_sy[SYNC-1];
  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign sel    = ~cs_s;
  assign miso   = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[6:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_byte   <= {rx_sr[6:0], mosi_s};
            byte_done <= 1'b1;
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) tx_sr <= tx_byte;
          else                 tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/scs_fifo.sv
module scs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign do_push   = in_valid & in_ready;
  assign do_pop    = out_valid & out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  output logic [7:0]       tx_byte,
  output logic             rxf_push,
  output logic [7:0]       rxf_data,
  input  logic             rxf_ready,
  input  logic [CW-1:0]    rx_cnt,
  output logic             txf_pop,
  input  logic [7:0]       txf_head,
  input  logic             txf_valid,
  input  logic [CW-1:0]    tx_cnt,
  output logic             fwr_beat,
  output logic [NSTAT-1:0] status,
  output logic             irq
);
  st_e             state;
  logic [CW-1:0]   left;
  logic [7:0]      hi_q;
  logic [REG_W-1:0] rd_q;
  logic            tx_have, fetch;
  logic [CW-1:0]   rx_thr, tx_thr;
  logic [NSTAT-1:0] ena;

  op_e             op;
  logic [3:0]      idx;
  logic [CW-1:0]   blen;
  logic            beat;
  assign op   = op_e'(rx_byte[7:5]);
  assign idx  = rx_byte[4:1];
  assign blen = (rx_byte[4:0] == 5'd0) ? CW'(DEPTH) : CW'(rx_byte[4:0]);
  assign beat = sel & byte_done;

  function automatic logic [REG_W-1:0] rmux(input logic [3:0] a);
    logic [REG_W-1:0] v;
    v = '0;
    case (a)
      IX_THR: v = REG_W'({tx_thr, rx_thr});
      IX_STS: v = REG_W'(status);
      IX_ENA: v = REG_W'(ena);
      IX_CNT: v = REG_W'({rx_cnt, tx_cnt});
      default: v = '0;
    endcase
    return v;
  endfunction

  logic             wr_en;
  logic [REG_W-1:0] wr_word;
  logic [NSTAT-1:0] clr;
  logic [3:0]       wr_idx;
  assign wr_en   = beat & (state == ST_WR_LO);
  assign wr_word = {hi_q, rx_byte};
  assign clr     = (wr_en && wr_idx == IX_CLR) ? wr_word[NSTAT-1:0] : '0;

  assign fwr_beat = beat & (state == ST_FWR);
  assign rxf_push = fwr_beat & rxf_ready;
  assign rxf_data = rx_byte;
  assign txf_pop  = beat & (state == ST_FRD) & tx_have;
  assign tx_byte  = (state == ST_SKIP || state == ST_CMD) ? 8'h00 : hi_q_tx;

  logic [7:0] hi_q_tx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      left    <= '0;
      hi_q    <= '0;
      rd_q    <= '0;
      hi_q_tx <= '0;
      tx_have <= 1'b0;
      fetch   <= 1'b0;
      wr_idx  <= '0;
    end else if (!sel) begin
      state   <= ST_CMD;
      hi_q_tx <= '0;
      tx_have <= 1'b0;
      fetch   <= 1'b0;
    end else if (byte_done) begin
      case (state)
        ST_CMD: begin
          case (op)
            OP_RREG: if (rx_byte[0]) begin
              rd_q    <= rmux(idx);
              hi_q_tx <= rmux(idx) >> 8;
              state   <= ST_RD_HI;
            end else state <= ST_SKIP;
            OP_WREG: if (rx_byte[0]) begin
              wr_idx <= idx;
              state  <= ST_WR_HI;
            end else state <= ST_SKIP;
            OP_RFIFO: begin
              left  <= blen;
              fetch <= 1'b1;
              state <= ST_FRD;
            end
            OP_WFIFO: begin
              left  <= blen;
              state <= ST_FWR;
            end
            default: state <= ST_SKIP;
          endcase
        end
        ST_RD_HI: begin
          hi_q_tx <= rd_q[7:0];
          state   <= ST_RD_LO;
        end
        ST_RD_LO: state <= ST_SKIP;
        ST_WR_HI: begin
          hi_q  <= rx_byte;
          state <= ST_WR_LO;
        end
        ST_WR_LO: state <= ST_SKIP;
        ST_FRD: begin
          tx_have <= 1'b0;
          hi_q_tx <= '0;
          left    <= left - CW'(1);
          if (left == CW'(1)) state <= ST_SKIP;
          else                fetch <= 1'b1;
        end
        ST_FWR: begin
          left <= left - CW'(1);
          if (left == CW'(1)) state <= ST_SKIP;
        end
        default: state <= ST_SKIP;
      endcase
    end else if (fetch) begin
      fetch   <= 1'b0;
      hi_q_tx <= txf_valid ? txf_head : 8'h00;
      tx_have <= txf_valid;
    end
  end

  logic [NSTAT-1:0] cond;
  always_comb begin
    cond         = '0;
    cond[SB_NE]  = (rx_cnt != '0);
    cond[SB_OVF] = fwr_beat & ~rxf_ready;
    cond[SB_OVT] = (rx_cnt > rx_thr);
    cond[SB_EMP] = (rx_cnt == '0);
    cond[SB_UNT] = (rx_cnt < rx_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr <= '0;
      tx_thr <= '0;
      ena    <= '0;
      status <= '0;
    end else begin
      status <= (status & ~clr) | cond;
      if (wr_en && wr_idx == IX_THR) {tx_thr, rx_thr} <= wr_word[2*CW-1:0];
      if (wr_en && wr_idx == IX_ENA) ena <= wr_word[NSTAT-1:0];
    end
  end

  assign irq = |(status & ena);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  input  logic       spi_cs_n,
  output logic       spi_miso,
  output logic       irq,
  input  logic       tx_in_valid,
  output logic       tx_in_ready,
  input  logic [7:0] tx_in_data,
  output logic       rx_out_valid,
  input  logic       rx_out_ready,
  output logic [7:0] rx_out_data
);
  logic          sel, byte_done;
  logic [7:0]    rx_byte, tx_byte;
  logic          rxf_push, rxf_ready, txf_pop, txf_valid, fwr_beat;
  logic [7:0]    rxf_data, txf_head;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [scs_pkg::NSTAT-1:0] status;

  scs_shift #(.SYNC(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .tx_byte(tx_byte), .miso(spi_miso), .sel(sel), .byte_done(byte_done),
    .rx_byte(rx_byte)
  );

  scs_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rxf_push), .in_ready(rxf_ready), .in_data(rxf_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_cnt)
  );

  scs_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(txf_valid), .out_ready(txf_pop), .out_data(txf_head),
    .count(tx_cnt)
  );

  scs_ctrl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done),
    .rx_byte(rx_byte), .tx_byte(tx_byte),
    .rxf_push(rxf_push), .rxf_data(rxf_data), .rxf_ready(rxf_ready), .rx_cnt(rx_cnt),
    .txf_pop(txf_pop), .txf_head(txf_head), .txf_valid(txf_valid), .tx_cnt(tx_cnt),
    .fwr_beat(fwr_beat), .status(status), .irq(irq)
  );
endmodule

// File: rtl/scs_chk.sv
module scs_chk #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_miso,
  input logic          tx_in_valid,
  input logic          fwr_beat,
  input logic          rxf_push,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [4:0]    status
);
  // R12
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

  // R12
  rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, rx_cnt} <= {1'b0, $past(rx_cnt)} + 1) &&
             ({1'b0, rx_cnt} + 1 >= {1'b0, $past(rx_cnt)}));

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwr_beat && rx_cnt == CW'(DEPTH)) |=> status[3]);

  // R8
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> (rx_cnt < CW'(DEPTH)));

  // R7
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0 && !tx_in_valid) |=> (tx_cnt == '0));

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);
endmodule

bind spi_cmd_slave scs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .tx_in_valid(tx_in_valid), .fwr_beat(fwr_beat), .rxf_push(rxf_push),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .status(status)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, irq;
  logic tx_in_valid = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic tx_in_ready;
  logic rx_out_valid;
  logic rx_out_ready = 1'b0;
  logic [7:0] rx_out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .irq(irq),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_d[$];
  string      exp_t[$];
  logic [7:0] obs_d[$];
  logic [7:0] tx_model[$];
  logic [7:0] rx_model[$];

  task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_d.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_d.pop_front();
        if (exp_d.size() == 0) begin
          e = 8'hxx; t = "unexpected";
        end else begin
          e = exp_d.pop_front(); t = exp_t.pop_front();
        end
        check({8'h00, o}, {8'h00, e}, t);
      end
    end
  end

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx);
    logic [7:0] r;
    spi_bits(tx, 8, r);
  endtask

  task automatic spi_rd(input logic [7:0] e, input string tag);
    logic [7:0] r;
    exp_d.push_back(e);
    exp_t.push_back(tag);
    spi_bits(8'h00, 8, r);
    obs_d.push_back(r);
  endtask

  task automatic spi_start();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_stop();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic reg_read(input logic [3:0] a, input logic [15:0] e, input string tag);
    spi_start();
    spi_byte({3'b000, a, 1'b1});
    spi_rd(e[15:8], tag);
    spi_rd(e[7:0], tag);
    spi_stop();
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] v);
    spi_start();
    spi_byte({3'b001, a, 1'b1});
    spi_byte(v[15:8]);
    spi_byte(v[7:0]);
    spi_stop();
  endtask

  function automatic logic [15:0] cnt_word();
    return 16'((rx_model.size() << 6) | tx_model.size());
  endfunction

  task automatic fifo_wr(input logic [4:0] n, input int k, input logic [7:0] base);
    int len;
    len = (n == 0) ? 32 : int'(n);
    spi_start();
    spi_byte({3'b101, n});
    for (int i = 0; i < k; i++) begin
      spi_byte(base + 8'(i));
      if (i < len && rx_model.size() < 32) rx_model.push_back(base + 8'(i));
    end
    spi_stop();
  endtask

  task automatic fifo_rd(input logic [4:0] n, input int k, input string tag);
    int len;
    len = (n == 0) ? 32 : int'(n);
    spi_start();
    spi_byte({3'b011, n});
    for (int i = 0; i < k; i++) begin
      if (i >= len) spi_rd(8'h00, "R11");
      else if (tx_model.size() > 0) spi_rd(tx_model.pop_front(), tag);
      else spi_rd(8'h00, "R7");
    end
    spi_stop();
  endtask

  task automatic core_push(input logic [7:0] d);
    @(negedge clk);
    tx_in_valid = 1'b1;
    tx_in_data  = d;
    while (!tx_in_ready) @(negedge clk);
    @(negedge clk);
    tx_in_valid = 1'b0;
    tx_model.push_back(d);
  endtask

  task automatic core_pop_all(input string tag);
    while (rx_model.size() > 0) begin
      @(negedge clk);
      check({15'd0, rx_out_valid}, 16'd1, tag);
      check({8'h00, rx_out_data}, {8'h00, rx_model.pop_front()}, tag);
      rx_out_ready = 1'b1;
      @(negedge clk);
      rx_out_ready = 1'b0;
    end
    @(negedge clk);
    check({15'd0, rx_out_valid}, 16'd0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] dummy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state: R1 R6 R10
    check({15'd0, miso}, 16'd0, "R1 reset miso");
    check({15'd0, irq}, 16'd0, "R10 reset irq");
    check({15'd0, tx_in_ready}, 16'd1, "R6 reset ready");
    check({15'd0, rx_out_valid}, 16'd0, "R5 reset valid");

    // R3 R9: counts and status after reset (only RX empty)
    reg_read(4'd4, 16'h0000, "R3 counts");
    reg_read(4'd1, 16'h0002, "R9 reset status");
    reg_read(4'd0, 16'h0000, "R3 thr reset");

    // R4: thresholds, TX=5 RX=3
    reg_write(4'd0, 16'h0143);
    reg_read(4'd0, 16'h0143, "R4 thr write");
    reg_write(4'd2, 16'h0004);
    reg_read(4'd2, 16'h0004, "R4 enable write");
    check({15'd0, irq}, 16'd0, "R10 no enabled status");

    // R5 R9 R10: burst write of five bytes
    fifo_wr(5'd5, 5, 8'hA0);
    reg_read(4'd4, cnt_word(), "R5 rx count");
    reg_read(4'd1, 16'h0017, "R9 status after write");
    check({15'd0, irq}, 16'd1, "R10 over threshold irq");
    core_pop_all("R5 rx order");

    // R9 clear: empty and under re-set at once
    reg_write(4'd3, 16'h001F);
    reg_read(4'd1, 16'h0003, "R9 clear and re-set");
    check({15'd0, irq}, 16'd0, "R10 irq cleared");
    reg_read(4'd3, 16'h0000, "R3 clear port reads 0");

    // R6 R7: TX burst longer than contents
    core_push(8'hC1);
    core_push(8'hC2);
    core_push(8'hC3);
    reg_read(4'd4, cnt_word(), "R6 tx count");
    fifo_rd(5'd5, 5, "R6 tx order");
    reg_read(4'd4, cnt_word(), "R7 count unchanged");

    // R11: bytes past burst length ignored
    fifo_wr(5'd2, 3, 8'h11);
    reg_read(4'd4, cnt_word(), "R11 burst truncation");
    core_pop_all("R11 rx data");

    // R8 R5: n=0 means 32, then overflow
    reg_write(4'd2, 16'h0008);
    fifo_wr(5'd0, 32, 8'h40);
    reg_read(4'd4, cnt_word(), "R5 length zero is 32");
    check({15'd0, irq}, 16'd0, "R8 no overflow yet");
    fifo_wr(5'd1, 1, 8'hEE);
    check({15'd0, irq}, 16'd1, "R8 overflow irq");
    reg_read(4'd1, 16'h001F, "R8 overflow status");
    reg_read(4'd4, cnt_word(), "R12 count capped");
    core_pop_all("R8 dropped byte absent");
    reg_write(4'd3, 16'h0008);
    check({15'd0, irq}, 16'd0, "R9 overflow cleared");

    // R11: abort mid byte during FIFO write and register write
    spi_start();
    spi_byte(8'hA4);
    spi_byte(8'h77);
    spi_bits(8'h99, 4, dummy);
    spi_stop();
    rx_model.push_back(8'h77);
    reg_read(4'd4, cnt_word(), "R11 partial byte dropped");
    core_pop_all("R11 complete byte kept");
    spi_start();
    spi_byte(8'h21);
    spi_byte(8'hAB);
    spi_stop();
    reg_read(4'd0, 16'h0143, "R11 register write aborted");

    // R4: read-only registers ignore writes
    reg_write(4'd4, 16'hFFFF);
    reg_write(4'd1, 16'hFFFF);
    reg_read(4'd4, cnt_word(), "R4 count not writable");
    reg_read(4'd2, 16'h0008, "R4 enable untouched");

    // R6 R12: fill TX queue
    for (int i = 0; i < 32; i++) core_push(8'h80 + 8'(i));
    @(negedge clk);
    check({15'd0, tx_in_ready}, 16'd0, "R6 ready low when full");
    reg_read(4'd4, cnt_word(), "R12 tx full count");
    fifo_rd(5'd0, 32, "R6 full burst order");
    @(negedge clk);
    check({15'd0, tx_in_ready}, 16'd1, "R6 ready after drain");

    // R2: invalid opcode and register command with bit0 low
    spi_start();
    spi_byte(8'h40);
    spi_rd(8'h00, "R2 invalid opcode");
    spi_byte(8'h55);
    spi_stop();
    spi_start();
    spi_byte(8'h00);
    spi_rd(8'h00, "R2 bit0 low read");
    spi_rd(8'h00, "R2 bit0 low read");
    spi_stop();
    spi_start();
    spi_byte(8'h20);
    spi_byte(8'hFF);
    spi_byte(8'hFF);
    spi_stop();
    reg_read(4'd0, 16'h0143, "R2 bit0 low write ignored");
    reg_read(4'd4, cnt_word(), "R2 no fifo change");

    repeat (20) @(negedge clk);
    if (exp_d.size() != 0) begin
      n_vec++;
      n_bad++;
      $display("FAIL scoreboard actual %0d left expected 0", exp_d.size());
    end
    finish_run();
  end
endmodule